// File: doc/BRIEF.md
# Strided Sub-Block Address Generator

This block walks a rectangular region held in a linear frame buffer as a series of equally spaced byte runs. It is loaded with four values: the address of the first byte of the first run, the number of bytes in each run, the byte distance from the start of one run to the start of the next, and how many runs there are. A start pulse captures these values. From the next cycle the block presents one byte address per cycle on a valid/ready output. Inside a run the address steps by one. After the last byte of a run, the next address is the start of that run plus the pitch.

Each address carries two flags. One marks the last byte of its run. The other marks the last byte of the whole region. A downstream memory engine can use these flags to close bursts and end the transfer. A pitch larger than the run length describes a region with gaps between runs. A pitch equal to the run length describes a contiguous block. All address arithmetic wraps modulo the width of the address.

Top module: `stride_addr_gen`

## Requirements
- R1: After reset the block is idle: `busy` and `addrValid` are low.
- R2: When `start` is high while the block is idle and both run length and run count are non-zero, `addrValid` rises in the next cycle and `addr` equals the captured base address.
- R3: Within a run, each accepted address (`addrValid` and `addrReady` both high) is followed by that address plus one.
- R4: After the last address of a run that is not the final run, the next address is the start address of that run plus the pitch, taken modulo 2^AW.
- R5: `runEnd` is high exactly on the run-length-th address of every run (offset run length minus one from the run start) and low on every other presented address.
- R6: `lastAddr` is high only on the final address of the final run, and `runEnd` is high whenever `lastAddr` is high.
- R7: A start with run length zero or run count zero presents no address: `busy` and `addrValid` stay low.
- R8: The configuration inputs are captured on the accepted start. Later changes to them do not alter the address sequence in progress.
- R9: A `start` pulse while `busy` is high is ignored, and the sequence in progress continues unchanged.
- R10: While `addrValid` is high and `addrReady` is low, `addr`, `runEnd` and `lastAddr` hold their values in the next cycle.
- R11: `busy` is high from the cycle after an accepted non-empty start until the final address is accepted, and it is low in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture the configuration and begin a walk |
| cfgBase | input | AW | Byte address of the first run's first byte |
| cfgRunLen | input | LW | Bytes per run |
| cfgPitch | input | AW | Byte distance between consecutive run starts |
| cfgRunCount | input | CW | Number of runs |
| addrValid | output | 1 | An address is presented |
| addrReady | input | 1 | The consumer accepts the presented address |
| addr | output | AW | Current byte address |
| runEnd | output | 1 | Presented address is the last byte of its run |
| lastAddr | output | 1 | Presented address is the last byte of the region |
| busy | output | 1 | A walk is in progress |

## Verification
The bench builds the block with a 12-bit address, a 4-bit run length and a 3-bit run count. These small widths make the largest runs (15 bytes) and the largest counts (7 runs) cheap to reach in one test. They also make address wrap-around past 0xFFF happen often under random bases and pitches. Random ready stalls, configuration churn during a walk, and spurious starts are mixed with directed cases: single-byte regions, zero length, zero count, contiguous pitch and a base just below the wrap point.

// File: rtl/stride_addr_gen_pkg.sv
package stride_addr_gen_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // capture configuration, point at first byte
    logic stepByte;  // advance one byte within the current run
    logic stepRun;   // jump to the next run start
  } sagStrobe_t;

  typedef enum logic {
    SAG_IDLE = 1'b0,
    SAG_RUN  = 1'b1
  } sagState_t;

endpackage

// File: rtl/stride_addr_dp.sv
module stride_addr_dp
  import stride_addr_gen_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sagStrobe_t    strobe,
  input  logic [AW-1:0] cfgBase,
  input  logic [LW-1:0] cfgRunLen,
  input  logic [AW-1:0] cfgPitch,
  input  logic [CW-1:0] cfgRunCount,
  output logic [AW-1:0] addrOut,
  output logic          atRunEnd,
  output logic          atLastRun,
  output logic          cfgEmpty
);

  localparam logic [LW-1:0] LEN_ONE = LW'(1);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [AW-1:0] addrQ;
  logic [AW-1:0] runBaseQ;
  logic [AW-1:0] pitchQ;
  logic [LW-1:0] lenQ;
  logic [LW-1:0] offQ;
  logic [CW-1:0] runsLeftQ;
  logic [AW-1:0] nextRunBase;

  assign nextRunBase = runBaseQ + pitchQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ     <= '0;
      runBaseQ  <= '0;
      pitchQ    <= '0;
      lenQ      <= '0;
      offQ      <= '0;
      runsLeftQ <= '0;
    end else if (strobe.load) begin
      addrQ     <= cfgBase;
      runBaseQ  <= cfgBase;
      pitchQ    <= cfgPitch;
      lenQ      <= cfgRunLen;
      offQ      <= '0;
      runsLeftQ <= cfgRunCount;
    end else if (strobe.stepRun) begin
      addrQ     <= nextRunBase;
      runBaseQ  <= nextRunBase;
      offQ      <= '0;
      runsLeftQ <= runsLeftQ - CNT_ONE;
    end else if (strobe.stepByte) begin
      addrQ <= addrQ + AW'(1);
      offQ  <= offQ + LEN_ONE;
    end
  end

  assign addrOut   = addrQ;
  assign atRunEnd  = (offQ == lenQ - LEN_ONE);
  assign atLastRun = (runsLeftQ == CNT_ONE);
  assign cfgEmpty  = (cfgRunLen == '0) || (cfgRunCount == '0);

  // A run jump always happens from the final byte of a run
  AST_RUNJUMP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.stepRun |-> (offQ == lenQ - LEN_ONE)) else $error("run jump before run end"); // R4

  // Offset never passes the run length while stepping
  AST_BYTE_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.stepByte |=> (offQ != '0) && (offQ < lenQ)) else $error("offset overrun"); // R5

  // No run jump when only one run is left
  AST_NO_JUMP_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.stepRun |-> (runsLeftQ > CNT_ONE)) else $error("jump past last run"); // R6

endmodule

// File: rtl/stride_addr_ctrl.sv
module stride_addr_ctrl
  import stride_addr_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       addrReady,
  input  logic       atRunEnd,
  input  logic       atLastRun,
  input  logic       cfgEmpty,
  output sagStrobe_t strobe,
  output logic       addrValid,
  output logic       runEnd,
  output logic       lastAddr,
  output logic       busy
);

  sagState_t stateQ, stateD;
  logic      startAccept;
  logic      fire;
  logic      finalFire;

  assign startAccept = start && (stateQ == SAG_IDLE);
  assign fire        = (stateQ == SAG_RUN) && addrReady;
  assign finalFire   = fire && atRunEnd && atLastRun;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      SAG_IDLE: if (startAccept && !cfgEmpty) stateD = SAG_RUN;
      SAG_RUN:  if (finalFire)                stateD = SAG_IDLE;
      default:                                stateD = SAG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= SAG_IDLE;
    else        stateQ <= stateD;
  end

  always_comb begin
    strobe          = '0;
    strobe.load     = startAccept;
    strobe.stepRun  = fire && atRunEnd && !atLastRun;
    strobe.stepByte = fire && !atRunEnd;
  end

  assign addrValid = (stateQ == SAG_RUN);
  assign busy      = (stateQ == SAG_RUN);
  assign runEnd    = addrValid && atRunEnd;
  assign lastAddr  = runEnd && atLastRun;

  // At most one strobe per cycle
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.load, strobe.stepRun, strobe.stepByte})) else $error("strobe clash"); // R9

  // Accepting the final address ends the walk
  AST_FINAL_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    (addrValid && addrReady && lastAddr) |=> !busy) else $error("busy after final"); // R11

  // An empty configuration never starts a walk
  AST_EMPTY_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && cfgEmpty) |=> !busy) else $error("empty walk started"); // R7

endmodule

// File: rtl/stride_addr_gen.sv
module stride_addr_gen
  import stride_addr_gen_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cfgBase,
  input  logic [LW-1:0] cfgRunLen,
  input  logic [AW-1:0] cfgPitch,
  input  logic [CW-1:0] cfgRunCount,
  output logic          addrValid,
  input  logic          addrReady,
  output logic [AW-1:0] addr,
  output logic          runEnd,
  output logic          lastAddr,
  output logic          busy
);

  sagStrobe_t strobe;
  logic       atRunEnd;
  logic       atLastRun;
  logic       cfgEmpty;

  stride_addr_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .addrReady (addrReady),
    .atRunEnd  (atRunEnd),
    .atLastRun (atLastRun),
    .cfgEmpty  (cfgEmpty),
    .strobe    (strobe),
    .addrValid (addrValid),
    .runEnd    (runEnd),
    .lastAddr  (lastAddr),
    .busy      (busy)
  );

  stride_addr_dp #(.AW(AW), .LW(LW), .CW(CW)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .cfgBase     (cfgBase),
    .cfgRunLen   (cfgRunLen),
    .cfgPitch    (cfgPitch),
    .cfgRunCount (cfgRunCount),
    .addrOut     (addr),
    .atRunEnd    (atRunEnd),
    .atLastRun   (atLastRun),
    .cfgEmpty    (cfgEmpty)
  );

  // Stalled output holds steady
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (addrValid && !addrReady) |=> (addrValid && $stable(addr) && $stable(runEnd) && $stable(lastAddr)))
    else $error("output moved under stall"); // R10

  // Accepted mid-run address is followed by the next byte
  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (addrValid && addrReady && !runEnd) |=> (addrValid && addr == $past(addr) + AW'(1)))
    else $error("byte step wrong"); // R3

  // Region end is also a run end
  AST_LAST_IS_RUNEND: assert property (@(posedge clk) disable iff (!rst_n)
    lastAddr |-> runEnd) else $error("last without run end"); // R6

  // Walk in progress keeps the output valid
  AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy == addrValid) else $error("busy and valid disagree"); // R11

endmodule

// File: tb/stride_addr_gen_tb.sv
module stride_addr_gen_tb;

  localparam int AW = 12;
  localparam int LW = 4;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] cfgBase = '0;
  logic [LW-1:0] cfgRunLen = '0;
  logic [AW-1:0] cfgPitch = '0;
  logic [CW-1:0] cfgRunCount = '0;
  logic          addrValid;
  logic          addrReady = 1'b0;
  logic [AW-1:0] addr;
  logic          runEnd;
  logic          lastAddr;
  logic          busy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  stride_addr_gen #(.AW(AW), .LW(LW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfgBase(cfgBase), .cfgRunLen(cfgRunLen), .cfgPitch(cfgPitch), .cfgRunCount(cfgRunCount),
    .addrValid(addrValid), .addrReady(addrReady), .addr(addr),
    .runEnd(runEnd), .lastAddr(lastAddr), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] expAddr(input logic [AW-1:0] base, input int len,
                                           input logic [AW-1:0] pitch, input int k);
    int run = k / len;
    int off = k % len;
    return AW'(int'(base) + run * int'(pitch) + off);
  endfunction

  task automatic runJob(input logic [AW-1:0] base, input int len, input logic [AW-1:0] pitch,
                        input int cnt, input bit churn);
    int total = len * cnt;
    int k = 0;
    bit holdPend = 1'b0;
    logic [AW-1:0] holdAddr = '0;
    bit holdRe = 1'b0, holdLa = 1'b0;
    @(negedge clk);
    cfgBase = base; cfgRunLen = LW'(len); cfgPitch = pitch; cfgRunCount = CW'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (total == 0) begin
      for (int i = 0; i < 3; i++) begin
        chk(!busy && !addrValid, "R7", "empty walk busy/valid", {busy, addrValid}, 0);
        @(negedge clk);
      end
      return;
    end
    chk(busy, "R11", "busy after start", busy, 1);
    while (k < total) begin
      bit r;
      if (holdPend) begin
        chk(addr == holdAddr && runEnd == holdRe && lastAddr == holdLa, "R10",
            "stall hold", addr, holdAddr);
        holdPend = 1'b0;
      end
      chk(addrValid && busy, "R11", "valid during walk", addrValid, 1);
      if (churn) begin
        cfgBase = AW'($urandom); cfgPitch = AW'($urandom);
        cfgRunLen = LW'($urandom); cfgRunCount = CW'($urandom);
        start = ($urandom % 6 == 0);
      end
      r = ($urandom % 4 != 0);
      addrReady = r;
      if (addrValid && r) begin
        logic [AW-1:0] e = expAddr(base, len, pitch, k);
        if (k == 0) chk(addr == e, "R2", "first address", addr, e);
        else if (k % len == 0) chk(addr == e, churn ? "R4/R8/R9" : "R4", "run start", addr, e);
        else chk(addr == e, churn ? "R3/R8/R9" : "R3", "byte step", addr, e);
        chk(runEnd == (k % len == len - 1), "R5", "runEnd", runEnd, (k % len == len - 1));
        chk(lastAddr == (k == total - 1), "R6", "lastAddr", lastAddr, (k == total - 1));
        k++;
      end else if (addrValid) begin
        holdPend = 1'b1; holdAddr = addr; holdRe = runEnd; holdLa = lastAddr;
      end
      @(negedge clk);
    end
    start = 1'b0;
    addrReady = 1'b0;
    chk(!busy && !addrValid, "R11", "idle after final", busy, 0);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !addrValid, "R1", "reset idle", {busy, addrValid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !addrValid, "R1", "idle after reset release", {busy, addrValid}, 0);

    runJob(12'h100, 1, 12'h010, 1, 1'b0);   // single byte region
    runJob(12'h200, 0, 12'h040, 3, 1'b0);   // zero length, R7
    runJob(12'h300, 5, 12'h040, 0, 1'b0);   // zero count, R7
    runJob(12'h400, 6, 12'h006, 4, 1'b0);   // contiguous pitch
    runJob(12'hFF8, 7, 12'h020, 3, 1'b0);   // wraps past top of address space
    runJob(12'h050, 15, 12'h100, 7, 1'b0);  // largest run and count
    runJob(12'h123, 4, 12'h080, 5, 1'b1);   // config churn and spurious starts, R8 R9

    for (int j = 0; j < 40; j++) begin
      runJob(AW'($urandom), int'($urandom % 16), AW'($urandom), int'($urandom % 8), j[0]);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule